// File: doc/BRIEF.md
# Synthesizer Loop Ratio Dividers

This block holds the two programmable counters that set the loop ratio of a frequency synthesizer. The reference pre-divider counts reference-clock events. Its ratio is a 7-bit field plus two. The feedback divider counts oscillator-clock events. Its ratio is twice a 10-bit base field, plus eight, plus a one-bit odd adjust. Each divider emits a one-cycle enable pulse once per division period. A phase detector uses these pulses.

The block runs on one fabric clock. The reference and oscillator edges arrive as single-cycle count enables (`ref_tick`, `fb_tick`) that have already been brought into this clock. Three byte-wide configuration registers hold the settings. A write port updates them, and a registered read port returns their contents. A new ratio takes effect only when a divider reaches its terminal count, so a division period in progress always finishes with the ratio it started with. A 3-bit pump setting shares a byte with the upper base-field bits and is passed straight to an output. The top three bits of that byte always read back a fixed constant.

Top module: `pll_div_ratio`

## Requirements
- R1: A synchronous active-high `rst` clears all configuration fields and loads both counters with their minimum ratios. After reset, with both enables high every cycle, the first `ref_pulse` follows the 2nd enable and the first `fb_pulse` follows the 8th. Address 0 reads 8'hA0, addresses 1 and 2 read 0, and `pump` is 0.
- R2: The reference ratio is Q+2, where Q is bits 6..0 of address 2. `ref_pulse` occurs once every Q+2 `ref_tick` events.
- R3: The feedback ratio is 2*(PB+4)+PO, where PO is bit 7 of address 2. PB is 10 bits: bits 1..0 of address 0 give PB[9:8] and address 1 gives PB[7:0]. `fb_pulse` occurs once every such number of `fb_tick` events.
- R4: The range ends are reached exactly: Q=127 gives 129, PB=0 with PO=0 gives 8, and PB=1023 with PO=1 gives 2055. No divider ever waits more ticks than its largest ratio.
- R5: A pulse is high for exactly one clock, in the cycle after the clock edge that samples the terminal enable. Cycles without an enable neither advance a counter nor produce a pulse.
- R6: A ratio written during a division period does not change that period. It applies from the period that starts after the next terminal count.
- R7: Bits 4..2 of address 0 appear on `pump` in the cycle after the write. `pump` changes only on a write to address 0.
- R8: Bits 7..5 of address 0 are read-only and read 3'b101. Writing them has no effect.
- R9: `rd_data` shows the register selected by `rd_addr` one clock later. Address 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 8 | Registered readback byte |
| ref_tick | input | 1 | One reference-clock event |
| fb_tick | input | 1 | One oscillator-clock event |
| ref_pulse | output | 1 | Reference divider terminal pulse |
| fb_pulse | output | 1 | Feedback divider terminal pulse |
| pump | output | 3 | Pump setting field |

## Verification
The reference ratio is swept over every Q value, so a wrong offset or a dropped bit shows up as a period-length mismatch. The feedback ratio is tried with base fields that hit each bit group, including both ends, under both values of the odd bit. This separates errors in the doubling, in the offset, and in placing the upper two bits. Enables that arrive only every other cycle show whether the counters advance on enables or on clocks, and whether a pulse lasts one cycle. A write in the middle of a period, followed by two measured periods, shows whether a new ratio waits for terminal count.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
  localparam logic [1:0] ADR_PBHI = 2'd0;  // fixed bits, pump, PB upper bits
  localparam logic [1:0] ADR_PBLO = 2'd1;  // PB lower byte
  localparam logic [1:0] ADR_QPO  = 2'd2;  // odd bit and reference field
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned PUMP_W  = 3;
  localparam int unsigned PUMP_LSB = 2;
endpackage

// File: rtl/pll_div_cfg.sv
module pll_div_cfg
  import pll_div_pkg::*;
#(
  parameter int unsigned QW = 7,
  parameter int unsigned PBW = 10,
  parameter logic [2:0] FIXED_TOP = 3'b101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [QW-1:0]     q_fld,
  output logic              po_bit,
  output logic [PBW-1:0]    pb_fld,
  output logic [PUMP_W-1:0] pump
);
  localparam int unsigned HI_W = PBW - BYTE_W;

  logic [HI_W-1:0]   pb_hi_r;
  logic [BYTE_W-1:0] pb_lo_r;
  logic [QW-1:0]     q_r;
  logic              po_r;
  logic [PUMP_W-1:0] pump_r;
  logic [BYTE_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      pb_hi_r <= '0;
      pb_lo_r <= '0;
      q_r     <= '0;
      po_r    <= 1'b0;
      pump_r  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_PBHI: begin
          pb_hi_r <= wr_data[HI_W-1:0];
          pump_r  <= wr_data[PUMP_LSB +: PUMP_W];
        end
        ADR_PBLO: pb_lo_r <= wr_data;
        ADR_QPO: begin
          q_r  <= wr_data[QW-1:0];
          po_r <= wr_data[BYTE_W-1];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      ADR_PBHI: begin
        rd_mux[BYTE_W-1 -: 3]         = FIXED_TOP;
        rd_mux[PUMP_LSB +: PUMP_W]    = pump_r;
        rd_mux[HI_W-1:0]              = pb_hi_r;
      end
      ADR_PBLO: rd_mux = pb_lo_r;
      ADR_QPO: begin
        rd_mux[BYTE_W-1] = po_r;
        rd_mux[QW-1:0]   = q_r;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  assign q_fld  = q_r;
  assign po_bit = po_r;
  assign pb_fld = {pb_hi_r, pb_lo_r};
  assign pump   = pump_r;
endmodule

// File: rtl/pll_div_counter.sv
module pll_div_counter #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_LOAD = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] ratio,
  output logic         pulse
);
  logic [W-1:0] cnt;
  logic         at_end;

  assign at_end = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= RST_LOAD;
      pulse <= 1'b0;
    end else begin
      pulse <= tick & at_end;
      if (tick) begin
        if (at_end) cnt <= ratio - W'(1);
        else        cnt <= cnt - W'(1);
      end
    end
  end
endmodule

// File: rtl/pll_div_ratio.sv
module pll_div_ratio
  import pll_div_pkg::*;
#(
  parameter int unsigned QW = 7,
  parameter int unsigned PBW = 10,
  parameter int unsigned Q_OFS = 2,
  parameter int unsigned PB_OFS = 4,
  parameter logic [2:0] FIXED_TOP = 3'b101
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [1:0]  rd_addr,
  output logic [7:0]  rd_data,
  input  logic        ref_tick,
  input  logic        fb_tick,
  output logic        ref_pulse,
  output logic        fb_pulse,
  output logic [2:0]  pump
);
  localparam int unsigned RW = QW + 1;
  localparam int unsigned FW = PBW + 2;
  localparam logic [RW-1:0] REF_LOAD0 = RW'(Q_OFS - 1);
  localparam logic [FW-1:0] FB_LOAD0  = FW'(2 * PB_OFS - 1);

  logic [QW-1:0]  q_fld;
  logic           po_bit;
  logic [PBW-1:0] pb_fld;
  logic [RW-1:0]  ref_ratio;
  logic [FW-1:0]  fb_ratio;

  pll_div_cfg #(.QW(QW), .PBW(PBW), .FIXED_TOP(FIXED_TOP)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .q_fld(q_fld), .po_bit(po_bit),
    .pb_fld(pb_fld), .pump(pump)
  );

  assign ref_ratio = RW'(q_fld) + RW'(Q_OFS);
  assign fb_ratio  = FW'({pb_fld, po_bit}) + FW'(2 * PB_OFS);

  pll_div_counter #(.W(RW), .RST_LOAD(REF_LOAD0)) u_ref (
    .clk(clk), .rst(rst), .tick(ref_tick), .ratio(ref_ratio), .pulse(ref_pulse)
  );

  pll_div_counter #(.W(FW), .RST_LOAD(FB_LOAD0)) u_fb (
    .clk(clk), .rst(rst), .tick(fb_tick), .ratio(fb_ratio), .pulse(fb_pulse)
  );
endmodule

// File: rtl/pll_div_chk.sv
module pll_div_chk #(
  parameter int unsigned QW = 7,
  parameter int unsigned PBW = 10,
  parameter int unsigned Q_OFS = 2,
  parameter int unsigned PB_OFS = 4,
  parameter logic [2:0] FIXED_TOP = 3'b101
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [1:0] rd_addr,
  input logic [7:0] rd_data,
  input logic       ref_tick,
  input logic       fb_tick,
  input logic       ref_pulse,
  input logic       fb_pulse,
  input logic [2:0] pump
);
  localparam logic [31:0] REF_MAX = 32'((1 << QW) - 1 + Q_OFS);
  localparam logic [31:0] FB_MAX  = 32'(2 * ((1 << PBW) - 1 + PB_OFS) + 1);

  logic [31:0] ref_gap;
  logic [31:0] fb_gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_gap <= '0;
      fb_gap  <= '0;
    end else begin
      ref_gap <= ref_pulse ? 32'(ref_tick) : ref_gap + 32'(ref_tick);
      fb_gap  <= fb_pulse  ? 32'(fb_tick)  : fb_gap  + 32'(fb_tick);
    end
  end

  AST_REF_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst) ref_pulse |=> !ref_pulse); // R5
  AST_FB_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst) fb_pulse |=> !fb_pulse); // R5
  AST_REF_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst) ref_pulse |-> $past(ref_tick)); // R5
  AST_FB_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst) fb_pulse |-> $past(fb_tick)); // R5
  AST_REF_GAP_BOUND: assert property (@(posedge clk) disable iff (rst) ref_gap <= REF_MAX); // R4
  AST_FB_GAP_BOUND: assert property (@(posedge clk) disable iff (rst) fb_gap <= FB_MAX); // R4
  AST_FIXED_READBACK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_addr) == 2'd0) |-> rd_data[7:5] == FIXED_TOP); // R8
  AST_PUMP_HELD: assert property (@(posedge clk) disable iff (rst)
    !($past(wr_en) && $past(wr_addr) == 2'd0) |-> $stable(pump)); // R7
endmodule

bind pll_div_ratio pll_div_chk #(
  .QW(QW), .PBW(PBW), .Q_OFS(Q_OFS), .PB_OFS(PB_OFS), .FIXED_TOP(FIXED_TOP)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
  .rd_data(rd_data), .ref_tick(ref_tick), .fb_tick(fb_tick),
  .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .pump(pump)
);

// File: tb/sim_pll_div_ratio.sv
`timescale 1ns/1ps
module sim_pll_div_ratio;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       ref_tick = 1'b0;
  logic       fb_tick = 1'b0;
  logic       ref_pulse;
  logic       fb_pulse;
  logic [2:0] pump;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pll_div_ratio u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ref_tick(ref_tick), .fb_tick(fb_tick),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .pump(pump)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic rt, input logic ft, output logic rp, output logic fp);
    ref_tick = rt;
    fb_tick  = ft;
    @(posedge clk);
    @(negedge clk);
    rp = ref_pulse;
    fp = fb_pulse;
    ref_tick = 1'b0;
    fb_tick  = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  // ticks up to and including the next pulse
  task automatic ref_count(output int n);
    logic rp, fp;
    n = 0;
    do begin step(1'b1, 1'b0, rp, fp); n++; end while (!rp && n < 5000);
  endtask

  task automatic fb_count(output int n);
    logic rp, fp;
    n = 0;
    do begin step(1'b0, 1'b1, rp, fp); n++; end while (!fp && n < 5000);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++; tests++;
    $display("FAIL R5 watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic rp, fp;
    logic [7:0] d;
    int n;
    int ref_first, fb_first;
    int pbs[6] = '{0, 1, 3, 170, 512, 1023};

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state and minimum ratios
    ref_first = 0; fb_first = 0;
    for (int i = 1; i <= 8; i++) begin
      step(1'b1, 1'b1, rp, fp);
      if (rp && ref_first == 0) ref_first = i;
      if (fp && fb_first == 0) fb_first = i;
    end
    check("R1", "first ref pulse tick", ref_first, 2);
    check("R1", "first fb pulse tick", fb_first, 8);
    rd(2'd0, d); check("R1", "addr0 after reset", d, 8'hA0);
    rd(2'd1, d); check("R1", "addr1 after reset", d, 0);
    rd(2'd2, d); check("R1", "addr2 after reset", d, 0);
    check("R1", "pump after reset", pump, 0);

    // R7 / R8: pump field and read-only top bits
    wr(2'd0, 8'hFF);
    check("R7", "pump after 0xFF", pump, 7);
    rd(2'd0, d); check("R8", "addr0 after 0xFF", d, 8'hBF);
    wr(2'd0, 8'h08);
    check("R7", "pump after 0x08", pump, 2);
    rd(2'd0, d); check("R8", "addr0 after 0x08", d, 8'hA8);
    wr(2'd1, 8'h5A);
    check("R7", "pump held across other write", pump, 2);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);

    // R9: unused address
    wr(2'd3, 8'hFF);
    rd(2'd3, d); check("R9", "addr3 readback", d, 0);
    rd(2'd1, d); check("R9", "addr1 untouched by addr3 write", d, 0);
    rd(2'd0, d); check("R9", "addr0 untouched by addr3 write", d, 8'hA0);

    // R2 / R4: reference ratio sweep over every Q
    for (int q = 0; q < 128; q++) begin
      wr(2'd2, 8'(q));
      ref_count(n);                  // finish current period, load new ratio
      ref_count(n);
      check(q == 127 ? "R4" : "R2", $sformatf("ref period Q=%0d", q), n, q + 2);
    end
    rd(2'd2, d); check("R2", "addr2 readback", d, 127);

    // R3 / R4: feedback ratio for selected PB values and both PO values
    for (int k = 0; k < 6; k++) begin
      for (int po = 0; po < 2; po++) begin
        logic [9:0] pb;
        pb = 10'(pbs[k]);
        wr(2'd0, {6'd0, pb[9:8]});
        wr(2'd1, pb[7:0]);
        wr(2'd2, {1'(po), 7'd0});
        fb_count(n);
        fb_count(n);
        check((pbs[k] == 1023 && po == 1) || (pbs[k] == 0 && po == 0) ? "R4" : "R3",
              $sformatf("fb period PB=%0d PO=%0d", pbs[k], po), n, 2 * (pbs[k] + 4) + po);
      end
    end
    rd(2'd0, d); check("R3", "addr0 PB high readback", d, 8'hA3);
    rd(2'd1, d); check("R3", "addr1 PB low readback", d, 8'hFF);

    // R5: sparse enables, single-cycle pulse, no counting without enable
    wr(2'd2, 8'd5);
    ref_count(n);
    n = 0;
    begin
      int idle_pulses = 0;
      rp = 1'b0;
      while (!rp && n < 500) begin
        step(1'b1, 1'b0, rp, fp);
        n++;
        begin
          logic rp2, fp2;
          step(1'b0, 1'b0, rp2, fp2);
          if (rp2 || fp2) idle_pulses++;
        end
      end
      check("R5", "ticks per period with sparse enables", n, 7);
      check("R5", "pulses in idle cycles", idle_pulses, 0);
    end

    // R6: mid-period ratio change, reference divider
    wr(2'd2, 8'd10);
    ref_count(n);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, rp, fp);
    wr(2'd2, 8'd3);
    ref_count(n); check("R6", "ref period in progress keeps old ratio", n, 9);
    ref_count(n); check("R6", "ref next period uses new ratio", n, 5);

    // R6: mid-period ratio change, feedback divider
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h80);
    fb_count(n);
    fb_count(n); check("R3", "fb period PB=0 PO=1", n, 9);
    for (int i = 0; i < 2; i++) step(1'b0, 1'b1, rp, fp);
    wr(2'd1, 8'd2);
    fb_count(n); check("R6", "fb period in progress keeps old ratio", n, 7);
    fb_count(n); check("R6", "fb next period uses new ratio", n, 13);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule